// File: doc/BRIEF.md
# Oscillator Alarm Escalation Controller

This block watches a bank of free-running oscillators that feed an entropy source. Each oscillator signals trouble with single-cycle alarm pulses. The controller keeps a separate alarm tally for each oscillator. When a tally reaches a programmable threshold, the controller records one error event for that oscillator. The first error event is only remembered. A second one shuts the oscillator down: its enable bit clears, its bit in a sticky stop register sets, and a shutdown-overflow pulse goes to the status logic.

Software controls the block through a small register port with a synchronous write and a combinational read. It can mask alarms per oscillator, store a per-oscillator detune word that drives the oscillator bank, read back which oscillators were stopped, and restart them by writing their enable bits again. Writing a 1 to an enable bit also wipes that oscillator's alarm history.

Top module: `osc_alarm_ctrl`

## Requirements
- R1: After reset, the threshold register reads 0x000000FF. The enable, detune, mask and stop registers read 0. `osc_en_o`, `detune_o` and `shut_ovf_o` are all 0.
- R2: The byte offsets are: threshold 0x1C (bits 7:0, upper bits read 0), enable 0x20, detune 0x24, alarm mask 0x28, alarm stop 0x2C. A write stores `wr_data_i` on the clock edge. `rd_data_o` shows the register chosen by `rd_addr_i` in the same cycle. Any other offset reads 0 and ignores writes. Writing 0 to the mask or stop register clears it.
- R3: `osc_en_o` and `detune_o` mirror the enable and detune registers. Bit i belongs to oscillator i. Detune has no other effect inside the block.
- R4: An alarm pulse (`alarm_i[i]` high at a clock edge) on an oscillator that is enabled and unmasked adds one to that oscillator's tally. When the tally reaches the threshold, one error event is counted and the tally returns to 0. A threshold of 0 behaves as 1.
- R5: The first error event of an oscillator causes no shutdown. The second one, at the same clock edge, clears its enable bit and sets its stop bit. The event history then starts over.
- R6: `shut_ovf_o` is high for exactly the one cycle after a clock edge at which one or more oscillators were shut down. Oscillators stopped at the same edge share one pulse.
- R7: Alarms on a masked oscillator or a disabled oscillator are ignored. They leave its tally and event history unchanged.
- R8: A write to the enable register with bit i = 1 clears oscillator i's tally and event history. An alarm on oscillator i at that same edge is discarded.
- R9: A shutdown wins over a software write to the enable or stop register at the same edge for the same oscillator. The enable bit ends 0 and the stop bit ends 1.
- R10: Oscillators escalate independently. Alarms on one never change another's tally, enable bit or stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| alarm_i | input | 32 | Per-oscillator alarm pulses |
| osc_en_o | output | 32 | Per-oscillator run enable |
| detune_o | output | 32 | Per-oscillator detune bits |
| shut_ovf_o | output | 1 | Shutdown-overflow pulse to status logic |

## Verification
The assertions check on every cycle that a shutdown clears the enable bit and leaves the stop bit set, even against a software write at the same edge. They also check that a masked or disabled oscillator never shuts down and that its tally stays unchanged. A further assertion checks that each overflow pulse matches an enable bit that has just fallen. Only the bench scenarios can show the exact alarm count that triggers a shutdown, the first-event grace, the effect of restarting through the enable register, the shared pulse for simultaneous stops, and the register map read-back.

// File: rtl/osc_alarm_pkg.sv
package osc_alarm_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_THR  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_DET  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STOP = 8'h2C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_THR, SEL_EN, SEL_DET, SEL_MASK, SEL_STOP
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_THR:  return SEL_THR;
      OFF_EN:   return SEL_EN;
      OFF_DET:  return SEL_DET;
      OFF_MASK: return SEL_MASK;
      OFF_STOP: return SEL_STOP;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/osc_alarm_regs.sv
module osc_alarm_regs
  import osc_alarm_pkg::*;
#(
  parameter int unsigned NUM_OSC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_W   = 8,
  parameter logic [THR_W-1:0] THR_RST = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_OSC-1:0] hw_stop_i,
  output logic [THR_W-1:0]   thr_o,
  output logic [NUM_OSC-1:0] en_o,
  output logic [NUM_OSC-1:0] det_o,
  output logic [NUM_OSC-1:0] mask_o,
  output logic [NUM_OSC-1:0] restart_o
);
  logic [THR_W-1:0]   thr_q;
  logic [NUM_OSC-1:0] en_q, det_q, mask_q, stop_q;
  logic [NUM_OSC-1:0] en_d, stop_d;
  reg_sel_e           wr_sel, rd_sel;

  assign wr_sel = wr_en_i ? decode_addr(wr_addr_i) : SEL_NONE;
  assign rd_sel = decode_addr(rd_addr_i);

  // hardware shutdown overrides a same-edge software write
  always_comb begin
    en_d   = (wr_sel == SEL_EN)   ? wr_data_i[NUM_OSC-1:0] : en_q;
    stop_d = (wr_sel == SEL_STOP) ? wr_data_i[NUM_OSC-1:0] : stop_q;
    en_d   = en_d & ~hw_stop_i;
    stop_d = stop_d | hw_stop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= THR_RST;
      en_q   <= '0;
      det_q  <= '0;
      mask_q <= '0;
      stop_q <= '0;
    end else begin
      if (wr_sel == SEL_THR)  thr_q  <= wr_data_i[THR_W-1:0];
      if (wr_sel == SEL_DET)  det_q  <= wr_data_i[NUM_OSC-1:0];
      if (wr_sel == SEL_MASK) mask_q <= wr_data_i[NUM_OSC-1:0];
      en_q   <= en_d;
      stop_q <= stop_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_sel)
      SEL_THR:  rd_data_o[THR_W-1:0]   = thr_q;
      SEL_EN:   rd_data_o[NUM_OSC-1:0] = en_q;
      SEL_DET:  rd_data_o[NUM_OSC-1:0] = det_q;
      SEL_MASK: rd_data_o[NUM_OSC-1:0] = mask_q;
      SEL_STOP: rd_data_o[NUM_OSC-1:0] = stop_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign restart_o = (wr_sel == SEL_EN) ? wr_data_i[NUM_OSC-1:0] : '0;
  assign thr_o     = thr_q;
  assign en_o      = en_q;
  assign det_o     = det_q;
  assign mask_o    = mask_q;

  AST_SHUT_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_stop_i) |=> ((en_q & $past(hw_stop_i)) == '0)); // R9
  AST_STOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_stop_i) |=> ((stop_q & $past(hw_stop_i)) == $past(hw_stop_i))); // R5
endmodule

// File: rtl/osc_alarm_lane.sv
module osc_alarm_lane #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alarm_i,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             shut_o
);
  logic [THR_W-1:0] tally_q;
  logic             evt_q;
  logic             take, hit;
  logic [THR_W:0]   tally_inc;

  assign take      = alarm_i & active_i & ~restart_i;
  assign tally_inc = {1'b0, tally_q} + 1'b1;
  // threshold 0 falls through as 1
  assign hit       = tally_inc >= {1'b0, thr_i};
  assign shut_o    = take & hit & evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tally_q <= '0;
      evt_q   <= 1'b0;
    end else if (restart_i) begin
      tally_q <= '0;
      evt_q   <= 1'b0;
    end else if (take) begin
      if (hit) begin
        tally_q <= '0;
        evt_q   <= ~evt_q;
      end else begin
        tally_q <= tally_inc[THR_W-1:0];
      end
    end
  end

  AST_IGNORED_ALARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i && !active_i && !restart_i) |=> ($stable(tally_q) && $stable(evt_q))); // R7
endmodule

// File: rtl/osc_alarm_ctrl.sv
module osc_alarm_ctrl
  import osc_alarm_pkg::*;
#(
  parameter int unsigned NUM_OSC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned THR_W   = 8,
  parameter logic [THR_W-1:0] THR_RST = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [7:0]         rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_OSC-1:0] alarm_i,
  output logic [NUM_OSC-1:0] osc_en_o,
  output logic [NUM_OSC-1:0] detune_o,
  output logic               shut_ovf_o
);
  logic [THR_W-1:0]   thr;
  logic [NUM_OSC-1:0] en_vec, mask_vec, restart_vec, shut_vec, active_vec;
  logic               ovf_q;

  osc_alarm_regs #(
    .NUM_OSC(NUM_OSC), .DATA_W(DATA_W), .THR_W(THR_W), .THR_RST(THR_RST)
  ) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .hw_stop_i (shut_vec),
    .thr_o     (thr),
    .en_o      (en_vec),
    .det_o     (detune_o),
    .mask_o    (mask_vec),
    .restart_o (restart_vec)
  );

  assign active_vec = en_vec & ~mask_vec;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_lane
    osc_alarm_lane #(.THR_W(THR_W)) lane_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alarm_i   (alarm_i[g]),
      .active_i  (active_vec[g]),
      .restart_i (restart_vec[g]),
      .thr_i     (thr),
      .shut_o    (shut_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= |shut_vec;
  end

  assign shut_ovf_o = ovf_q;
  assign osc_en_o   = en_vec;

  AST_SHUT_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shut_vec & ~(en_vec & ~mask_vec)) == '0)); // R7
  AST_OVF_MATCHES_EN_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_ovf_o |-> (($past(osc_en_o) & ~osc_en_o) != '0)); // R6
endmodule

// File: tb/osc_alarm_ctrl_tb.sv
module osc_alarm_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] alarm = '0;
  logic [31:0] osc_en, detune;
  logic        shut_ovf;

  int tests = 0, fails = 0, ovf_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  osc_alarm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .alarm_i(alarm), .osc_en_o(osc_en), .detune_o(detune), .shut_ovf_o(shut_ovf)
  );

  always @(posedge clk) begin
    #1;
    if (shut_ovf) ovf_cnt++;
  end

  // {addr, write data, expected read}
  localparam logic [95:0] VEC [9] = '{
    {32'h1C, 32'hDEADBE5A, 32'h0000005A},
    {32'h20, 32'h0F0FA5A5, 32'h0F0FA5A5},
    {32'h24, 32'h13579BDF, 32'h13579BDF},
    {32'h28, 32'hFFFF0000, 32'hFFFF0000},
    {32'h2C, 32'h000000FF, 32'h000000FF},
    {32'h30, 32'hFFFFFFFF, 32'h00000000},
    {32'h2C, 32'h00000000, 32'h00000000},
    {32'h28, 32'h00000000, 32'h00000000},
    {32'h1C, 32'h00000003, 32'h00000003}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [31:0] v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      alarm = v;
      @(negedge clk);
      alarm = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ovf", {31'd0, shut_ovf}, 32'd0);
    check("R1 osc_en", osc_en, 32'd0);
    check("R1 detune", detune, 32'd0);
    rd(8'h1C, d); check("R1 thr", d, 32'h000000FF);
    rd(8'h2C, d); check("R1 stop", d, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 register table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      check("R2 readback", d, VEC[i][31:0]);
      if (VEC[i][71:64] == 8'h20) check("R3 osc_en", osc_en, VEC[i][63:32]);
      if (VEC[i][71:64] == 8'h24) check("R3 detune", detune, VEC[i][63:32]);
    end
    check("R3 osc_en hold", osc_en, 32'h0F0FA5A5);

    wr(8'h20, 32'hFFFFFFFF);
    base = ovf_cnt;

    // R4 R5 R6 osc0 with threshold 3
    pulse(32'h1, 3);
    check("R5 first event no shutdown", osc_en, 32'hFFFFFFFF);
    check("R4 no ovf yet", ovf_cnt - base, 0);
    pulse(32'h1, 2);
    check("R4 below threshold", osc_en, 32'hFFFFFFFF);
    @(negedge clk); alarm = 32'h1; @(negedge clk); alarm = '0;
    check("R6 pulse high", {31'd0, shut_ovf}, 32'd1);
    check("R5 enable cleared", osc_en, 32'hFFFFFFFE);
    rd(8'h2C, d); check("R5 stop set", d, 32'h1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'd0, shut_ovf}, 32'd0);
    check("R6 pulse count", ovf_cnt - base, 1);

    // R7 masked alarms ignored
    wr(8'h28, 32'h2);
    pulse(32'h2, 5);
    check("R7 masked no shutdown", osc_en, 32'hFFFFFFFE);
    wr(8'h28, 32'h0);
    pulse(32'h2, 5);
    check("R7 tally untouched by mask", osc_en, 32'hFFFFFFFE);
    pulse(32'h2, 1);
    check("R7 shutdown after unmask", osc_en, 32'hFFFFFFFC);
    base = ovf_cnt;
    pulse(32'h1, 6);
    check("R7 disabled osc ignored", ovf_cnt - base, 0);
    rd(8'h2C, d); check("R7 stop unchanged", d, 32'h3);

    // R8 restart clears history
    pulse(32'h4, 4);
    wr(8'h20, 32'hFFFFFFFF);
    wr(8'h2C, 32'h0);
    pulse(32'h4, 5);
    check("R8 history cleared", osc_en, 32'hFFFFFFFF);
    pulse(32'h4, 1);
    check("R8 shutdown after restart", osc_en, 32'hFFFFFFFB);

    // R9 shutdown beats same-edge stop write
    pulse(32'h8, 5);
    @(negedge clk);
    alarm = 32'h8; wr_en = 1'b1; wr_addr = 8'h2C; wr_data = 32'h0;
    @(negedge clk);
    alarm = '0; wr_en = 1'b0;
    rd(8'h2C, d); check("R9 stop kept", d, 32'h8);
    check("R9 enable cleared", osc_en, 32'hFFFFFFF3);

    // R10 simultaneous independent shutdowns share a pulse
    pulse(32'h60, 5);
    check("R10 no early shutdown", osc_en, 32'hFFFFFFF3);
    base = ovf_cnt;
    pulse(32'h60, 1);
    check("R10 both stopped", osc_en, 32'hFFFFFF93);
    check("R6 shared pulse", ovf_cnt - base, 1);
    rd(8'h2C, d); check("R10 stop bits", d, 32'h68);

    // R4 threshold 0 acts as 1
    wr(8'h1C, 32'h0);
    pulse(32'h80, 1);
    check("R4 thr0 first", osc_en, 32'hFFFFFF93);
    pulse(32'h80, 1);
    check("R4 thr0 second", osc_en, 32'hFFFFFF13);

    // R8 alarm at enable-write edge discarded
    pulse(32'h100, 1);
    @(negedge clk);
    alarm = 32'h100; wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'hFFFFFF13;
    @(negedge clk);
    alarm = '0; wr_en = 1'b0;
    check("R8 same-edge alarm discarded", osc_en, 32'hFFFFFF13);
    pulse(32'h100, 1);
    check("R8 one event after restart", osc_en, 32'hFFFFFF13);
    pulse(32'h100, 1);
    check("R8 shutdown on second", osc_en, 32'hFFFFFE13);
    check("R3 detune kept", detune, 32'h13579BDF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule